// File: doc/BRIEF.md
# Data Object Mailbox Responder

This block is the device side of a dword-wide mailbox through which a host exchanges variable-length data objects with a local responder. The host writes a request object one dword at a time into a write-data register and then sets a go bit. The block checks that the object is complete and well formed, then streams it out to the local responder with a valid/ready handshake. The responder's reply comes back on a second stream, is buffered on chip, and is handed to the host through a read-data register that advances only when the host writes to it.

Every object opens with two header dwords. The first holds a 16-bit vendor identifier in bits [15:0] and an 8-bit object type in bits [23:16]; the block passes these through untouched. The second holds, in bits [17:0], the object length in dwords counting both headers, where zero stands for 2^18 dwords. A status register reports busy, error and response-ready. An abort bit drops any work in flight in both directions, returns busy and error to zero on the next clock, and tells the responder to drop its work through a one-cycle pulse.

Top module: `dobj_mailbox`

## Requirements
- R1: After reset the status register reads zero, the read-data register reads zero and req_valid is low.
- R2: Register word addresses are 0 control, 1 status, 2 write data, 3 read data. Control bit 0 is abort and bit 31 is go. Status bit 0 is busy, bit 2 is error and bit 31 is response-ready. Reads of control and write data return zero.
- R3: After an accepted go, the dwords written since the last go, abort or rejected go leave on the request stream in write order, with req_last on the final one only. Busy reads 1 from the cycle after go until the cycle after the response beat carrying rsp_last is taken.
- R4: Go is accepted only when at least two dwords were written and their count equals the length decoded from bits [17:0] of the second dword. A field of zero decodes to 2^18, and a decoded length below 2 is malformed. A rejected go sets error, starts nothing and discards the written dwords.
- R5: A write to write-data while busy, or while the request buffer already holds REQ_DEPTH dwords, is dropped and sets error.
- R6: Error stays set until an abort. While error is set, go starts nothing.
- R7: Response beats taken while busy are stored in order. Response-ready reads 1 while any stored dword remains, and reading read-data returns the oldest one without removing it.
- R8: Any write to read-data removes the oldest stored dword. With nothing stored, read-data reads zero and such a write changes nothing.
- R9: A control write with bit 0 set empties both buffers and clears busy and error by the next cycle, and drives peer_abort high for exactly that one following cycle.
- R10: Response beats that arrive while no response is awaited are taken (rsp_ready high) and discarded.
- R11: While a response is awaited and RSP_DEPTH dwords are stored, rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| req_valid | output | 1 | Request stream beat valid |
| req_ready | input | 1 | Request stream beat accepted by the responder |
| req_data | output | 32 | Request stream dword |
| req_last | output | 1 | Final dword of the request object |
| rsp_valid | input | 1 | Response stream beat valid |
| rsp_ready | output | 1 | Response stream beat can be taken |
| rsp_data | input | 32 | Response stream dword |
| rsp_last | input | 1 | Final dword of the response object |
| peer_abort | output | 1 | One-cycle pulse telling the responder to drop its work |

## Verification
The main exchange is swept over every object length the request buffer can hold, from a bare two-dword header up to a full buffer. Each length is paired with a different response length, so a wrong last-beat position, a lost or repeated dword, or a read pointer that moves on a read shows up as a data mismatch. Malformed objects are tried with one dword only, a length field of one, a length field of zero and a count short of the header length; these tell the length decoding and the count comparison apart. An over-long response with no host reads in progress separates correct back-pressure from overflow. An abort issued mid-request, with a response stored, and followed by stray response beats shows whether both directions are really flushed.

// File: rtl/dobj_pkg.sv
`timescale 1ns/1ps
package dobj_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LEN_W = 18;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_STAT  = 2'd1;
  localparam logic [1:0] A_WDATA = 2'd2;
  localparam logic [1:0] A_RDATA = 2'd3;

  localparam int unsigned C_ABORT = 0;
  localparam int unsigned C_GO    = 31;
  localparam int unsigned S_BUSY  = 0;
  localparam int unsigned S_ERR   = 2;
  localparam int unsigned S_READY = 31;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEND = 2'd1,
    PH_RESP = 2'd2
  } phase_t;
endpackage

// File: rtl/dobj_fifo.sv
`timescale 1ns/1ps
module dobj_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic [W-1:0]                   din,
  input  logic                           pop,
  output logic [W-1:0]                   head,
  output logic                           empty,
  output logic                           full,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  mem [DEPTH];
  logic          mem_we;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign mem_we = push && !flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = step(wr_q);
      if (pop)  rd_d = step(rd_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_q] <= din;
  end

  assign head  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dobj_len_track.sv
`timescale 1ns/1ps
module dobj_len_track
  import dobj_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             accept,
  input  logic [LEN_W-1:0] len_field,
  output logic             obj_ok
);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam int unsigned LW = LEN_W + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] len_q, len_d;

  always_comb begin
    cnt_d = cnt_q;
    len_d = len_q;
    if (clear) begin
      cnt_d = '0;
      len_d = '0;
    end else if (accept) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(1)) begin
        len_d = (len_field == '0) ? (LW'(1) << LEN_W) : {1'b0, len_field};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign obj_ok = (cnt_q >= CW'(2)) && (len_q >= LW'(2)) && (len_q == LW'(cnt_q));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/dobj_ctrl.sv
`timescale 1ns/1ps
module dobj_ctrl
  import dobj_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   abort,
  input  logic   start,
  input  logic   send_done,
  input  logic   resp_done,
  input  logic   err_set,
  output phase_t phase,
  output logic   error
);
  phase_t ph_q, ph_d;
  logic   err_q, err_d;

  always_comb begin
    ph_d = ph_q;
    if (abort) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE: if (start)     ph_d = PH_SEND;
        PH_SEND: if (send_done) ph_d = PH_RESP;
        PH_RESP: if (resp_done) ph_d = PH_IDLE;
        default:                ph_d = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    err_d = err_q;
    if (abort)        err_d = 1'b0;
    else if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      err_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      err_q <= err_d;
    end
  end

  assign phase = ph_q;
  assign error = err_q;

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !abort) |=> err_q);
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (ph_q == PH_IDLE) && !err_q);
endmodule

// File: rtl/dobj_mailbox.sv
`timescale 1ns/1ps
module dobj_mailbox
  import dobj_pkg::*;
#(
  parameter int unsigned REQ_DEPTH = 8,
  parameter int unsigned RSP_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [31:0]   req_data,
  output logic          req_last,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [31:0]   rsp_data,
  input  logic          rsp_last,
  output logic          peer_abort
);
  localparam int unsigned RQ_CW = $clog2(REQ_DEPTH+1);
  localparam int unsigned RS_CW = $clog2(RSP_DEPTH+1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  // register decode
  logic wr_ctrl, abort_cmd, go_cmd, wr_wdata, wr_rdata;
  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign abort_cmd = wr_ctrl && reg_wdata[C_ABORT];
  assign go_cmd    = wr_ctrl && reg_wdata[C_GO] && !reg_wdata[C_ABORT];
  assign wr_wdata  = reg_wr && (reg_addr == A_WDATA);
  assign wr_rdata  = reg_wr && (reg_addr == A_RDATA);

  phase_t phase;
  logic   busy, error, in_resp;
  logic   obj_ok, go_start, go_reject, err_write;
  logic   rq_push, rq_pop, rq_flush, rq_empty, rq_full;
  logic   rs_push, rs_pop, rs_empty, rs_full;
  logic [31:0]      rq_head, rs_head;
  logic [RQ_CW-1:0] rq_cnt;
  logic [RS_CW-1:0] rs_cnt;
  logic   send_done, resp_done, peer_abort_q;

  assign busy      = (phase != PH_IDLE);
  assign in_resp   = (phase == PH_RESP);
  assign rq_push   = wr_wdata && !busy && !rq_full;
  assign err_write = wr_wdata && (busy || rq_full);
  assign go_start  = go_cmd && !busy && !error && obj_ok;
  assign go_reject = go_cmd && !busy && !error && !obj_ok;
  assign rq_flush  = abort_cmd || go_reject;

  // request side
  dobj_fifo #(.W(DW), .DEPTH(REQ_DEPTH)) u_req_buf (
    .clk(clk), .rst_n(rst_s_n), .flush(rq_flush),
    .push(rq_push), .din(reg_wdata), .pop(rq_pop),
    .head(rq_head), .empty(rq_empty), .full(rq_full), .count(rq_cnt)
  );

  dobj_len_track #(.DEPTH(REQ_DEPTH)) u_len (
    .clk(clk), .rst_n(rst_s_n),
    .clear(abort_cmd || go_start || go_reject),
    .accept(rq_push), .len_field(reg_wdata[LEN_W-1:0]), .obj_ok(obj_ok)
  );

  assign req_valid = (phase == PH_SEND) && !rq_empty;
  assign req_data  = rq_head;
  assign req_last  = (rq_cnt == RQ_CW'(1));
  assign rq_pop    = req_valid && req_ready;
  assign send_done = rq_pop && req_last;

  // response side
  assign rsp_ready = in_resp ? !rs_full : 1'b1;
  assign rs_push   = rsp_valid && in_resp && !rs_full;
  assign resp_done = rs_push && rsp_last;
  assign rs_pop    = wr_rdata && !rs_empty;

  dobj_fifo #(.W(DW), .DEPTH(RSP_DEPTH)) u_rsp_buf (
    .clk(clk), .rst_n(rst_s_n), .flush(abort_cmd),
    .push(rs_push), .din(rsp_data), .pop(rs_pop),
    .head(rs_head), .empty(rs_empty), .full(rs_full), .count(rs_cnt)
  );

  dobj_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .abort(abort_cmd), .start(go_start),
    .send_done(send_done), .resp_done(resp_done),
    .err_set(err_write || go_reject), .phase(phase), .error(error)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) peer_abort_q <= 1'b0;
    else        peer_abort_q <= abort_cmd;
  end
  assign peer_abort = peer_abort_q;

  // register read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: begin
        reg_rdata[S_BUSY]  = busy;
        reg_rdata[S_ERR]   = error;
        reg_rdata[S_READY] = !rs_empty;
      end
      A_RDATA: if (!rs_empty) reg_rdata = rs_head;
      default: reg_rdata = '0;
    endcase
  end

  assert_req_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_valid |-> busy);
  assert_done_frees_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (resp_done && !abort_cmd) |=> !busy);
  assert_abort_flush_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    abort_cmd |=> rq_empty && rs_empty && peer_abort);
  assert_rdata_zero_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((reg_addr == A_RDATA) && rs_empty) |-> (reg_rdata == '0));
  assert_stray_dropped_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rsp_valid && !in_resp && !rs_pop && !abort_cmd) |=> $stable(rs_cnt));
  assert_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_resp && rs_full) |-> !rsp_ready);
endmodule

// File: tb/dobj_mailbox_tb.sv
`timescale 1ns/1ps
module dobj_mailbox_tb;
  import dobj_pkg::*;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_last, rsp_ready, peer_abort;
  logic [31:0] req_data;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        rsp_last = 1'b0;

  always #2.5 clk = ~clk;

  dobj_mailbox #(.REQ_DEPTH(DEPTH), .RSP_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data), .req_last(req_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .peer_abort(peer_abort)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] cap_d [512];
  logic        cap_l [512];
  int cap_n = 0;
  int pa_n  = 0;

  always @(posedge clk) begin
    if (req_valid && req_ready) begin
      cap_d[cap_n % 512] <= req_data;
      cap_l[cap_n % 512] <= req_last;
      cap_n <= cap_n + 1;
    end
    if (peer_abort) pa_n <= pa_n + 1;
  end

  always @(negedge clk) req_ready <= ~req_ready;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] st(input bit b, input bit e, input bit r);
    logic [31:0] v;
    v = '0;
    v[S_BUSY] = b; v[S_ERR] = e; v[S_READY] = r;
    return v;
  endfunction

  function automatic logic [31:0] req_word(input int seed, input int k, input int lf);
    if (k == 0) return {8'h00, 8'(seed), 16'h1E00 + 16'(seed)};
    if (k == 1) return 32'(lf);
    return 32'hA500_0000 | 32'(seed << 8) | 32'(k);
  endfunction

  function automatic logic [31:0] rsp_word(input int seed, input int j);
    return 32'hC000_0000 | 32'(seed << 8) | 32'(j);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic put_obj(input int n, input int lf, input int seed);
    for (int k = 0; k < n; k++) wr(A_WDATA, req_word(seed, k, lf));
  endtask

  task automatic send_rsp(input int n, input int seed);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = rsp_word(seed, j); rsp_last = (j == n-1);
      #1;
      while (!rsp_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    rsp_valid = 1'b0; rsp_last = 1'b0;
  endtask

  task automatic wait_cap(input int target);
    int lim = 0;
    while (cap_n < target && lim < 1000) begin
      @(negedge clk);
      lim++;
    end
  endtask

  logic [31:0] v, v2;
  int base, pa0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_STAT, v);  chk("R1 status after reset", v, 32'h0);
    rd(A_RDATA, v); chk("R1 read-data after reset", v, 32'h0);
    chk("R1 req_valid after reset", {31'h0, req_valid}, 32'h0);
    rd(A_CTRL, v);  chk("R2 control reads zero", v, 32'h0);

    // main sweep over every request length the buffer holds
    for (int L = 2; L <= DEPTH; L++) begin
      int m;
      m = ((L * 3) % DEPTH) + 1;
      base = cap_n;
      put_obj(L, L, L);
      rd(A_WDATA, v); chk("R2 write-data reads zero", v, 32'h0);
      wr(A_CTRL, 32'h8000_0000);
      rd(A_STAT, v); chk("R3 busy after go", v, st(1, 0, 0));
      wait_cap(base + L);
      for (int k = 0; k < L; k++) begin
        chk("R3 request dword", cap_d[(base + k) % 512], req_word(L, k, L));
        chk("R3 request last flag", {31'h0, cap_l[(base + k) % 512]}, {31'h0, (k == L-1)});
      end
      rd(A_STAT, v); chk("R3 busy awaiting response", v, st(1, 0, 0));
      send_rsp(m, L);
      rd(A_STAT, v); chk("R3 R7 idle with response held", v, st(0, 0, 1));
      rd(A_RDATA, v); rd(A_RDATA, v2);
      chk("R7 read does not consume", v2, v);
      for (int j = 0; j < m; j++) begin
        rd(A_STAT, v); chk("R7 ready while dwords remain", v, st(0, 0, 1));
        rd(A_RDATA, v); chk("R8 response dword in order", v, rsp_word(L, j));
        wr(A_RDATA, 32'h0);
      end
      rd(A_STAT, v);  chk("R8 ready clear when drained", v, st(0, 0, 0));
      rd(A_RDATA, v); chk("R8 read-data zero when empty", v, 32'h0);
    end

    // R8 pop with nothing stored
    wr(A_RDATA, 32'h1234);
    rd(A_STAT, v); chk("R8 empty pop changes nothing", v, st(0, 0, 0));

    // R4 malformed and incomplete objects
    base = cap_n;
    put_obj(1, 0, 11); wr(A_CTRL, 32'h8000_0000);
    rd(A_STAT, v); chk("R4 single dword rejected", v, st(0, 1, 0));
    wr(A_CTRL, 32'h1);
    put_obj(2, 1, 12); wr(A_CTRL, 32'h8000_0000);
    rd(A_STAT, v); chk("R4 length one malformed", v, st(0, 1, 0));
    wr(A_CTRL, 32'h1);
    put_obj(2, 0, 13); wr(A_CTRL, 32'h8000_0000);
    rd(A_STAT, v); chk("R4 length zero means 2^18", v, st(0, 1, 0));
    wr(A_CTRL, 32'h1);
    put_obj(3, 5, 14); wr(A_CTRL, 32'h8000_0000);
    rd(A_STAT, v); chk("R4 short count rejected", v, st(0, 1, 0));
    repeat (4) @(negedge clk);
    chk("R4 nothing sent on rejected go", 32'(cap_n), 32'(base));
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v); chk("R9 abort clears error", v, st(0, 0, 0));
    put_obj(3, 3, 15); wr(A_CTRL, 32'h8000_0000);
    wait_cap(base + 3);
    for (int k = 0; k < 3; k++)
      chk("R4 clean object after rejects", cap_d[(base + k) % 512], req_word(15, k, 3));
    send_rsp(1, 15);
    wr(A_RDATA, 32'h0);

    // R6 error sticky, go blocked
    base = cap_n;
    put_obj(1, 0, 16); wr(A_CTRL, 32'h8000_0000);
    put_obj(3, 3, 17); wr(A_CTRL, 32'h8000_0000);
    rd(A_STAT, v); chk("R6 go blocked while error", v, st(0, 1, 0));
    repeat (4) @(negedge clk);
    chk("R6 nothing sent while error", 32'(cap_n), 32'(base));
    pa0 = pa_n;
    wr(A_CTRL, 32'h8000_0001);
    rd(A_STAT, v); chk("R9 abort wins over go", v, st(0, 0, 0));
    chk("R9 one peer_abort pulse", 32'(pa_n), 32'(pa0 + 1));
    wr(A_CTRL, 32'h8000_0000);
    rd(A_STAT, v); chk("R9 abort emptied request buffer", v, st(0, 1, 0));
    wr(A_CTRL, 32'h1);

    // R5 overflow
    put_obj(DEPTH, DEPTH + 1, 18);
    rd(A_STAT, v); chk("R5 full buffer no error yet", v, st(0, 0, 0));
    wr(A_WDATA, 32'hDEAD_0009);
    rd(A_STAT, v); chk("R5 write past capacity", v, st(0, 1, 0));
    wr(A_CTRL, 32'h1);

    // R5 write while busy, then abort mid exchange
    put_obj(2, 2, 19); wr(A_CTRL, 32'h8000_0000);
    wr(A_WDATA, 32'h5555_0000);
    rd(A_STAT, v); chk("R5 write while busy", v, st(1, 1, 0));
    pa0 = pa_n;
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v); chk("R9 abort clears busy and error", v, st(0, 0, 0));
    chk("R9 peer_abort pulse count", 32'(pa_n), 32'(pa0 + 1));
    chk("R9 req_valid low after abort", {31'h0, req_valid}, 32'h0);

    // R10 stray response beats
    send_rsp(3, 20);
    rd(A_STAT, v);  chk("R10 stray beats discarded", v, st(0, 0, 0));
    rd(A_RDATA, v); chk("R10 read-data stays zero", v, 32'h0);

    // R9 abort with stored response
    base = cap_n;
    put_obj(2, 2, 21); wr(A_CTRL, 32'h8000_0000);
    wait_cap(base + 2);
    send_rsp(4, 21);
    rd(A_STAT, v); chk("R7 response stored", v, st(0, 0, 1));
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v);  chk("R9 abort empties response", v, st(0, 0, 0));
    rd(A_RDATA, v); chk("R9 read-data zero after abort", v, 32'h0);

    // R11 back-pressure with a response longer than the buffer
    base = cap_n;
    put_obj(2, 2, 22); wr(A_CTRL, 32'h8000_0000);
    wait_cap(base + 2);
    fork
      send_rsp(DEPTH + 2, 22);
      begin
        int lim = 0;
        @(negedge clk);
        while (rsp_ready && lim < 200) begin
          @(negedge clk);
          lim++;
        end
        chk("R11 ready low when buffer full", {31'h0, rsp_ready}, 32'h0);
        rd(A_STAT, v); chk("R11 busy and ready while full", v, st(1, 0, 1));
        for (int j = 0; j < DEPTH + 2; j++) begin
          int w = 0;
          rd(A_STAT, v);
          while (!v[S_READY] && w < 200) begin
            rd(A_STAT, v);
            w++;
          end
          rd(A_RDATA, v); chk("R11 no dword lost", v, rsp_word(22, j));
          wr(A_RDATA, 32'h0);
        end
      end
    join
    rd(A_STAT, v); chk("R11 idle after long response", v, st(0, 0, 0));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule